// File: doc/BRIEF.md
# Serial UART with infrared pulse encoding

This block is an asynchronous serial transmitter and receiver. Bytes written into a 16-entry transmit queue are sent as framed characters. Each frame has a low start bit, five to eight data bits sent least significant bit first, an optional parity bit, and one or two high stop bits. Characters arriving on the receive line are stored, together with their status flags, in a 16-entry receive queue. Both queues can be cut down to a single-byte holding register. One programmable divider produces a sampling tick, and sixteen ticks make one bit period.

The receiver rejects start bits that are really glitches and recognises a line held low as a break. It raises a timeout when stored characters sit unread while the line stays quiet. An infrared pulse stage can take over the serial path. In that stage a zero bit becomes a short high pulse and a one bit sends nothing. The pulse width is either 3/16 of a bit or, in low-power mode, three periods of a separately divided pulse clock.

Top module: `sir_uart`

## Requirements
- R1: After reset, serial_out is 1, sir_out is 0, tx_full is 0, rx_empty is 1 and rx_timeout is 0. One bit period is 16 ticks, and a tick comes every cfg_baud_div clocks (a value of 0 counts as 1). Transmit bit boundaries fall on a fixed grid every 16×cfg_baud_div clocks counted from reset release, so a frame starts at the first boundary after data is queued.
- R2: cfg_wlen encodes the word length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits go out least significant first. A received word is right-aligned in rx_data, with the unused upper bits zero.
- R3: A frame is sent in this order: the start bit (0), the data bits, a parity bit if cfg_par_en is 1, then one stop bit (1), plus a second stop bit if cfg_stop2 is 1. With cfg_par_even set to 1 the parity bit is the XOR of the data bits; with it set to 0 the parity bit is the inverse of that XOR.
- R4: Each queue holds 16 entries when cfg_fifo_en is 1 and 1 entry when it is 0. tx_full reports that the transmit queue is at capacity. A write while full is dropped, a received character that finds the receive queue full is dropped, and a read while empty is ignored.
- R5: A start bit that is no longer low when sampled 8 ticks after the falling edge is discarded, and nothing is stored.
- R6: The receiver samples each bit at its midpoint. rx_perr is set when the parity bit received does not match the parity computed from the received data. rx_ferr is set when the first stop bit is sampled low. All flags travel with their word through the queue.
- R7: While cfg_break is 1, the sent line is held at zero. On receive, a frame sampled low at every position through the stop bit is stored once, with data 0, rx_brk=1 and rx_ferr=1. No new frame is accepted until the line has been high for at least one tick.
- R8: When cfg_sir_en is 1, serial_out stays at 1. If cfg_sir_lp is 0, each zero bit drives sir_out high during ticks 6 to 8 of that bit, and a one bit leaves sir_out low.
- R9: With cfg_sir_en and cfg_sir_lp both 1, sir_out goes high at tick 6 of each zero bit and stays high for 3×(cfg_lp_div+1) clocks. cfg_lp_div ranges from 0 to 511, giving a pulse clock of 1 to 512 reference clocks.
- R10: With cfg_sir_en set to 1, the receiver takes its input from sir_in. Each rising edge there counts as a zero bit lasting one bit period.
- R11: rx_timeout is high when the receive queue is not empty and 32 bit periods (512 ticks) have passed since the last start detection, stored character or read. A read clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_baud_div | input | 16 | Clocks per sampling tick |
| cfg_wlen | input | 2 | Word length code (5 to 8 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 selects even parity, 0 selects odd |
| cfg_stop2 | input | 1 | Two stop bits |
| cfg_fifo_en | input | 1 | 1 gives 16-entry queues, 0 gives a 1-entry holding register |
| cfg_break | input | 1 | Force the sent line to zero |
| cfg_sir_en | input | 1 | Route the serial path through the infrared pulse stage |
| cfg_sir_lp | input | 1 | Low-power pulse width |
| cfg_lp_div | input | 9 | Pulse clock divisor minus one |
| tx_data | input | 8 | Byte to queue for sending |
| tx_push | input | 1 | Write tx_data into the transmit queue |
| tx_full | output | 1 | Transmit queue at capacity |
| rx_pop | input | 1 | Remove the head word from the receive queue |
| rx_data | output | 8 | Head word data |
| rx_perr | output | 1 | Head word parity error |
| rx_ferr | output | 1 | Head word framing error |
| rx_brk | output | 1 | Head word is a break |
| rx_empty | output | 1 | Receive queue empty |
| rx_timeout | output | 1 | Unread data with a quiet line |
| serial_in | input | 1 | Plain serial receive line |
| serial_out | output | 1 | Plain serial transmit line |
| sir_in | input | 1 | Infrared pulse receive input |
| sir_out | output | 1 | Infrared pulse transmit output |

## Verification
The bench targets these corner cases:

- **Bit grid and frame layout.** These are checked on every clock for every word length, parity and stop setting. A misplaced parity bit or a missing second stop bit shows up as a line mismatch on the affected bit.
- **Queue limits.** A burst larger than the queue, and the single-byte mode, test capacity. A queue that accepted a write while full would deliver an extra character.
- **Bad receive frames.** A short low glitch, a wrong parity bit, a low stop bit and a held break are each injected. A receiver without glitch rejection would store an all-ones character, and one that did not wait for the line to go high would store a stream of break entries.
- **Pulse width and timeout.** Pulse widths are compared per cycle in both infrared modes. The timeout is probed just before and just after 32 bit periods, so an off-by-one counter limit or a missed clear on read is caught.

// File: rtl/sir_uart.sv
module sir_uart #(
  parameter int DEPTH   = 16,
  parameter int DIVW    = 16,
  parameter int TO_BITS = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DIVW-1:0] cfg_baud_div,
  input  logic [1:0]      cfg_wlen,
  input  logic            cfg_par_en,
  input  logic            cfg_par_even,
  input  logic            cfg_stop2,
  input  logic            cfg_fifo_en,
  input  logic            cfg_break,
  input  logic            cfg_sir_en,
  input  logic            cfg_sir_lp,
  input  logic [8:0]      cfg_lp_div,
  input  logic [7:0]      tx_data,
  input  logic            tx_push,
  output logic            tx_full,
  input  logic            rx_pop,
  output logic [7:0]      rx_data,
  output logic            rx_perr,
  output logic            rx_ferr,
  output logic            rx_brk,
  output logic            rx_empty,
  output logic            rx_timeout,
  input  logic            serial_in,
  output logic            serial_out,
  input  logic            sir_in,
  output logic            sir_out
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int TOW = $clog2(TO_BITS * 16 + 1);
  localparam logic [TOW-1:0] TO_TICKS = TOW'(TO_BITS * 16);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  // shared timing
  logic [DIVW-1:0] os_cnt;
  logic [3:0] tx_ph;
  wire [DIVW-1:0] div_m1 = (cfg_baud_div == '0) ? '0 : cfg_baud_div - 1'b1;
  wire tick = (os_cnt == div_m1);
  wire bb = tick && (tx_ph == 4'd15);
  wire [3:0] wl = {2'b00, cfg_wlen} + 4'd5;
  wire [7:0] wmask = 8'hFF >> (4'd8 - wl);
  wire [CW-1:0] cap = cfg_fifo_en ? CW'(DEPTH) : CW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      os_cnt <= '0;
      tx_ph  <= '0;
    end else if (tick) begin
      os_cnt <= '0;
      tx_ph  <= tx_ph + 4'd1;
    end else begin
      os_cnt <= os_cnt + 1'b1;
    end

  // transmit queue
  logic [7:0] tx_mem [DEPTH];
  logic [AW-1:0] tx_wr, tx_rd;
  logic [CW-1:0] tx_cnt;
  logic [3:0] tx_rem;
  logic [11:0] tx_sh, tx_frame;
  logic tx_line;

  assign tx_full = (tx_cnt >= cap);
  wire tx_in   = tx_push && !tx_full;
  wire tx_load = bb && (tx_rem == 4'd0) && (tx_cnt != '0);

  always_ff @(posedge clk)
    if (tx_in) tx_mem[tx_wr] <= tx_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wr  <= '0;
      tx_rd  <= '0;
      tx_cnt <= '0;
    end else begin
      if (tx_in)   tx_wr <= (tx_wr == LAST_IDX) ? '0 : tx_wr + 1'b1;
      if (tx_load) tx_rd <= (tx_rd == LAST_IDX) ? '0 : tx_rd + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_in) - CW'(tx_load);
    end

  wire [7:0] td = tx_mem[tx_rd] & wmask;
  wire td_par = cfg_par_even ? ^td : ~^td;

  always_comb begin
    tx_frame = '1;
    tx_frame[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (i < int'(wl)) tx_frame[i+1] = td[i];
    if (cfg_par_en) tx_frame[wl + 4'd1] = td_par;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_line <= 1'b1;
      tx_sh   <= '1;
      tx_rem  <= '0;
    end else if (bb) begin
      if (tx_rem != 4'd0) begin
        tx_line <= tx_sh[0];
        tx_sh   <= {1'b1, tx_sh[11:1]};
        tx_rem  <= tx_rem - 4'd1;
      end else if (tx_cnt != '0) begin
        tx_line <= 1'b0;
        tx_sh   <= {1'b1, tx_frame[11:1]};
        tx_rem  <= wl + {3'b000, cfg_par_en} + 4'd1 + {3'b000, cfg_stop2};
      end else begin
        tx_line <= 1'b1;
      end
    end

  // line output and pulse encoder
  wire tx_bit = tx_line && !cfg_break;
  logic [1:0] lp_rem;
  logic [8:0] lp_cnt;
  wire lp_fire = cfg_sir_en && cfg_sir_lp && tick && (tx_ph == 4'd5) && !tx_bit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lp_rem <= '0;
      lp_cnt <= '0;
    end else if (lp_fire) begin
      lp_rem <= 2'd3;
      lp_cnt <= '0;
    end else if (lp_rem != 2'd0) begin
      if (lp_cnt == cfg_lp_div) begin
        lp_cnt <= '0;
        lp_rem <= lp_rem - 2'd1;
      end else begin
        lp_cnt <= lp_cnt + 9'd1;
      end
    end

  wire sir_norm = !tx_bit && (tx_ph >= 4'd6) && (tx_ph <= 4'd8);
  assign serial_out = cfg_sir_en || tx_bit;
  assign sir_out = cfg_sir_en && (cfg_sir_lp ? (lp_rem != 2'd0) : sir_norm);

  // receive input conditioning
  logic [1:0] s_ser, s_sir;
  logic sir_d;
  logic [4:0] dcnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s_ser <= 2'b11;
      s_sir <= 2'b00;
      sir_d <= 1'b0;
      dcnt  <= '0;
    end else begin
      s_ser <= {s_ser[0], serial_in};
      s_sir <= {s_sir[0], sir_in};
      sir_d <= s_sir[1];
      if (s_sir[1] && !sir_d) dcnt <= 5'd16;
      else if (tick && dcnt != 5'd0) dcnt <= dcnt - 5'd1;
    end

  wire rx_line = cfg_sir_en ? (dcnt == 5'd0) : s_ser[1];

  // receive framing
  logic armed, busy, allz, rx_pb;
  logic [3:0] rc, bidx;
  logic [7:0] rx_sh;
  wire [3:0] last = wl + {3'b000, cfg_par_en} + 4'd1;
  wire start_det = tick && !busy && armed && !rx_line;
  wire samp = tick && busy && (rc == 4'd7);
  wire rx_store = samp && (bidx == last);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      armed <= 1'b0;
      busy  <= 1'b0;
      allz  <= 1'b0;
      rx_pb <= 1'b0;
      rc    <= '0;
      bidx  <= '0;
      rx_sh <= '0;
    end else if (tick) begin
      if (!busy) begin
        armed <= rx_line;
        if (armed && !rx_line) begin
          busy <= 1'b1;
          rc   <= '0;
          bidx <= '0;
          allz <= 1'b1;
        end
      end else begin
        rc <= rc + 4'd1;
        if (rc == 4'd7) begin
          if (bidx == 4'd0 && rx_line) begin
            busy <= 1'b0;
          end else begin
            bidx <= bidx + 4'd1;
            if (bidx != 4'd0 && bidx <= wl) rx_sh <= {rx_line, rx_sh[7:1]};
            if (cfg_par_en && bidx == wl + 4'd1) rx_pb <= rx_line;
            if (bidx != 4'd0 && rx_line) allz <= 1'b0;
            if (bidx == last) begin
              busy  <= 1'b0;
              armed <= 1'b0;
            end
          end
        end
      end
    end

  wire [7:0] rd_data = rx_sh >> (4'd8 - wl);
  wire rd_par = cfg_par_even ? ^rd_data : ~^rd_data;
  wire [10:0] rd_word = {allz && !rx_line, !rx_line, cfg_par_en && (rx_pb != rd_par), rd_data};

  // receive queue
  logic [10:0] rx_mem [DEPTH];
  logic [AW-1:0] rx_wr, rx_rd;
  logic [CW-1:0] rx_cnt;
  logic [TOW-1:0] to_cnt;
  wire rx_in  = rx_store && (rx_cnt < cap);
  wire rx_out = rx_pop && (rx_cnt != '0);

  always_ff @(posedge clk)
    if (rx_in) rx_mem[rx_wr] <= rd_word;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_wr  <= '0;
      rx_rd  <= '0;
      rx_cnt <= '0;
      to_cnt <= '0;
    end else begin
      if (rx_in)  rx_wr <= (rx_wr == LAST_IDX) ? '0 : rx_wr + 1'b1;
      if (rx_out) rx_rd <= (rx_rd == LAST_IDX) ? '0 : rx_rd + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_in) - CW'(rx_out);
      if (start_det || rx_in || rx_out) to_cnt <= '0;
      else if (tick && rx_cnt != '0 && to_cnt != TO_TICKS) to_cnt <= to_cnt + 1'b1;
    end

  assign {rx_brk, rx_ferr, rx_perr, rx_data} = rx_mem[rx_rd];
  assign rx_empty = (rx_cnt == '0);
  assign rx_timeout = (to_cnt == TO_TICKS) && !rx_empty;
endmodule

// File: rtl/sir_uart_chk.sv
module sir_uart_chk #(
  parameter int DEPTH = 16
) (
  input logic clk,
  input logic rst_n,
  input logic cfg_sir_en,
  input logic cfg_break,
  input logic tx_full,
  input logic tx_load,
  input logic serial_out,
  input logic rx_pop,
  input logic rx_empty,
  input logic rx_timeout,
  input logic [$clog2(DEPTH+1)-1:0] tx_cnt,
  input logic [$clog2(DEPTH+1)-1:0] rx_cnt
);
  assert_fifo_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= DEPTH) && (rx_cnt <= DEPTH));

  assert_full_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && !tx_load) |=> (tx_cnt == $past(tx_cnt)));

  assert_start_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && !cfg_sir_en && !cfg_break) |=> (!serial_out || cfg_sir_en || cfg_break));

  assert_timeout_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_timeout |-> !rx_empty);

  assert_pop_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && !rx_empty) |=> !rx_timeout);
endmodule

bind sir_uart sir_uart_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_sir_en(cfg_sir_en), .cfg_break(cfg_break),
  .tx_full(tx_full), .tx_load(tx_load), .serial_out(serial_out),
  .rx_pop(rx_pop), .rx_empty(rx_empty), .rx_timeout(rx_timeout),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/tb_sir_uart.sv
module tb_sir_uart;
  localparam int DIV = 2;
  localparam int BIT = 16 * DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] cfg_baud_div = 16'(DIV);
  logic [1:0] cfg_wlen = 2'd3;
  logic cfg_par_en = 0, cfg_par_even = 0, cfg_stop2 = 0, cfg_fifo_en = 1;
  logic cfg_break = 0, cfg_sir_en = 0, cfg_sir_lp = 0;
  logic [8:0] cfg_lp_div = '0;
  logic [7:0] tx_data = '0;
  logic tx_push = 0, rx_pop = 0;
  logic tx_full, rx_perr, rx_ferr, rx_brk, rx_empty, rx_timeout;
  logic [7:0] rx_data;
  logic serial_out, sir_out;
  logic loop = 1, drv = 1;
  wire serial_in = loop ? serial_out : drv;

  sir_uart dut (
    .clk(clk), .rst_n(rst_n), .cfg_baud_div(cfg_baud_div), .cfg_wlen(cfg_wlen),
    .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even), .cfg_stop2(cfg_stop2),
    .cfg_fifo_en(cfg_fifo_en), .cfg_break(cfg_break), .cfg_sir_en(cfg_sir_en),
    .cfg_sir_lp(cfg_sir_lp), .cfg_lp_div(cfg_lp_div), .tx_data(tx_data),
    .tx_push(tx_push), .tx_full(tx_full), .rx_pop(rx_pop), .rx_data(rx_data),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk), .rx_empty(rx_empty),
    .rx_timeout(rx_timeout), .serial_in(serial_in), .serial_out(serial_out),
    .sir_in(sir_out), .sir_out(sir_out)
  );

  always #5 clk = ~clk;

  int nchecks = 0, nfail = 0, cyc = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference for the sent line
  int e, lp_left, mcap, mw;
  bit mline, macc, mbit;
  bit bitq[$];
  logic [7:0] byteq[$];
  logic [10:0] exprx[$];
  logic [7:0] md, mm;

  always @(posedge clk) begin
    if (!rst_n) begin
      e = 0; mline = 1; lp_left = 0;
      bitq.delete(); byteq.delete();
    end else begin
      mcap = cfg_fifo_en ? 16 : 1;
      macc = tx_push && (byteq.size() < mcap);
      mbit = mline && !cfg_break;
      e++;
      if (lp_left > 0) lp_left--;
      if (cfg_sir_en && cfg_sir_lp && (e % DIV == 0) && (((e - 1) / DIV) % 16 == 5) && !mbit)
        lp_left = 3 * (int'(cfg_lp_div) + 1);
      if (e % BIT == 0) begin
        if (bitq.size() > 0) mline = bitq.pop_front();
        else if (byteq.size() > 0) begin
          mw = int'(cfg_wlen) + 5;
          md = byteq.pop_front() & (8'hFF >> (8 - mw));
          for (int i = 0; i < mw; i++) bitq.push_back(md[i]);
          if (cfg_par_en) bitq.push_back(cfg_par_even ? ^md : ~^md);
          bitq.push_back(1'b1);
          if (cfg_stop2) bitq.push_back(1'b1);
          mline = 0;
        end else mline = 1;
      end
      if (macc) begin
        byteq.push_back(tx_data);
        mm = 8'hFF >> (8 - (int'(cfg_wlen) + 5));
        if (exprx.size() < mcap) exprx.push_back({3'b000, tx_data & mm});
      end
    end
  end

  // per-clock comparison
  int ph;
  bit esir;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      ph = (e / DIV) % 16;
      chk(cfg_sir_en ? "R8 serial_out" : (cfg_break ? "R7 serial_out" : "R1 R3 serial_out"),
          32'(serial_out), 32'(cfg_sir_en || (mline && !cfg_break)));
      if (cfg_sir_lp) esir = cfg_sir_en && (lp_left > 0);
      else esir = cfg_sir_en && !(mline && !cfg_break) && ph >= 6 && ph <= 8;
      chk(cfg_sir_lp ? "R9 sir_out" : "R8 sir_out", 32'(sir_out), 32'(esir));
      chk("R4 tx_full", 32'(tx_full), 32'(byteq.size() >= (cfg_fifo_en ? 16 : 1)));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
    end
  end

  task automatic push_burst(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tx_push = 1; tx_data = base + 8'(i * 37);
    end
    @(negedge clk);
    tx_push = 0;
  endtask

  task automatic wait_done();
    do @(posedge clk); while (byteq.size() != 0 || bitq.size() != 0);
    repeat (4 * BIT) @(negedge clk);
  endtask

  task automatic pop_check(input string tag, input logic [10:0] exp);
    @(negedge clk);
    chk({tag, " rx_empty"}, 32'(rx_empty), 32'd0);
    chk({tag, " rx word"}, 32'({rx_brk, rx_ferr, rx_perr, rx_data}), 32'(exp));
    rx_pop = 1;
    @(negedge clk);
    rx_pop = 0;
  endtask

  task automatic drain(input string tag);
    while (exprx.size() > 0) pop_check(tag, exprx.pop_front());
    @(negedge clk);
    chk({tag, " drained"}, 32'(rx_empty), 32'd1);
  endtask

  task automatic send_line(input logic [11:0] bits, input int n);
    for (int i = 0; i < n; i++) begin
      drv = bits[i];
      repeat (BIT) @(negedge clk);
    end
    drv = 1;
    repeat (3 * BIT) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset serial_out", 32'(serial_out), 32'd1);
    chk("R1 reset sir_out", 32'(sir_out), 32'd0);
    chk("R1 reset tx_full", 32'(tx_full), 32'd0);
    chk("R1 reset rx_empty", 32'(rx_empty), 32'd1);
    chk("R1 reset rx_timeout", 32'(rx_timeout), 32'd0);
    rst_n = 1;
    repeat (2 * BIT) @(negedge clk);

    // R2 R3: formats in loopback
    push_burst(2, 8'hA5); wait_done(); drain("R2 w8");
    cfg_wlen = 0; cfg_par_en = 1; cfg_par_even = 1; cfg_stop2 = 1;
    push_burst(3, 8'h1F); wait_done(); drain("R2 R3 w5 even 2stop");
    cfg_wlen = 1; cfg_par_even = 0; cfg_stop2 = 0;
    push_burst(3, 8'h6B); wait_done(); drain("R2 R3 w6 odd");
    cfg_wlen = 2; cfg_par_even = 1;
    push_burst(2, 8'hF0); wait_done(); drain("R2 R3 w7 even");

    // R4: burst beyond capacity, then single-entry mode
    cfg_wlen = 3; cfg_par_en = 0;
    push_burst(20, 8'h11); wait_done(); drain("R4 burst");
    cfg_fifo_en = 0;
    push_burst(3, 8'h42); wait_done();
    push_burst(1, 8'h24); wait_done(); drain("R4 single");
    cfg_fifo_en = 1;

    // R5: glitch shorter than half a bit
    loop = 0;
    @(negedge clk); drv = 0;
    repeat (3 * DIV) @(negedge clk);
    drv = 1;
    repeat (3 * BIT) @(negedge clk);
    chk("R5 false start stored nothing", 32'(rx_empty), 32'd1);

    // R6: parity and framing errors
    cfg_par_en = 1; cfg_par_even = 1;
    send_line({1'b0, 1'b1, 1'b0, 8'h01, 1'b0}, 11);
    pop_check("R6 parity error", {3'b001, 8'h01});
    cfg_par_en = 0;
    send_line({2'b00, 1'b0, 8'h55, 1'b0}, 10);
    pop_check("R6 framing error", {3'b010, 8'h55});

    // R7: break sent and received
    loop = 1;
    @(negedge clk); cfg_break = 1;
    repeat (15 * BIT) @(negedge clk);
    cfg_break = 0;
    repeat (4 * BIT) @(negedge clk);
    pop_check("R7 break", {3'b110, 8'h00});
    @(negedge clk);
    chk("R7 single break entry", 32'(rx_empty), 32'd1);

    // R11: receive timeout
    push_burst(1, 8'h3C); wait_done();
    chk("R11 no timeout early", 32'(rx_timeout), 32'd0);
    repeat (26 * BIT) @(negedge clk);
    chk("R11 no timeout at 29 bits", 32'(rx_timeout), 32'd0);
    repeat (4 * BIT) @(negedge clk);
    chk("R11 timeout after 32 bits", 32'(rx_timeout), 32'd1);
    exprx.delete();
    pop_check("R11 timed-out word", {3'b000, 8'h3C});
    chk("R11 cleared by read", 32'(rx_timeout), 32'd0);

    // R8 R9 R10: pulse modes with decoded loopback
    cfg_sir_en = 1;
    push_burst(3, 8'h00); wait_done(); drain("R8 R10 sir normal");
    cfg_sir_lp = 1; cfg_lp_div = 9'd2;
    push_burst(2, 8'h96); wait_done(); drain("R9 R10 sir lp div3");
    cfg_lp_div = 9'd0;
    push_burst(1, 8'h0F); wait_done(); drain("R9 R10 sir lp div1");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end
endmodule